// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block links two W-bit ports, A and B, with one storage bank per direction. A bank either follows its source port clock by clock (pass mode) or freezes the last value it took (hold mode). It presents that value toward the opposite port. Each direction has three active-low controls: a master enable, a latch enable and an output enable. The master enable gates both the bank update and the port driver. The pad three-state buffers sit outside the block. Each port is therefore shown as a data vector plus a drive-enable vector, and the pad ring wires these to its buffers.

Everything runs on one system clock. Each bank is a two-state machine. In BANK_PASS the bank loads its source port at every clock edge. In BANK_HOLD it keeps its content. The transition named "open" (HOLD to PASS) is taken at an edge that samples master enable and latch enable both low. The transition named "capture" (PASS to HOLD) is taken at an edge that samples either of them high. Because of this, a rising master enable freezes the bank in the same way as a rising latch enable. A four-state bus arbiter registers which side is asking to drive. Its states are BUS_IDLE (nobody), BUS_TO_B (A-to-B side only), BUS_TO_A (B-to-A side only) and BUS_CLASH (both sides). From any state it moves to whichever of the four states matches the request pair sampled at the current edge. In BUS_CLASH the block raises a contention flag and drives neither port.

Top module: `dual_latch_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both banks to zero, puts both banks in hold, sets both drive-enable vectors to all zeros and clears the contention flag.
- R2: Pass mode (A-to-B). While the A-to-B master enable and latch enable are both sampled low (0), b_out shows, one cycle later, the a_in value sampled at the previous edge.
- R3: Take an edge at which the A-to-B latch enable is first sampled high (1) while the master enable stays low. The value on a_in at that edge is the last one taken, and b_out keeps it afterwards.
- R4: Take an edge at which the A-to-B master enable is first sampled high while the latch enable stays low. The value on a_in at that edge is the last one taken, in the same way as for R3.
- R5: While the latch enable of a direction is sampled high, changes on its source port do not alter that bank's output.
- R6: A port's drive-enable vector is all ones in the cycle after an edge that samples that direction's master enable and output enable both low, and no clash. Otherwise it is all zeros. The data vector always shows the bank content.
- R7: A master enable sampled high blocks both the bank update and the drive of that direction, whatever its latch enable and output enable are.
- R8: The B-to-A direction (b_in into a bank, shown on a_out with a_drv) follows R2 to R7 with its own three controls.
- R9: When both directions request drive at the same edge, clash is 1 in the next cycle and a_drv and b_drv are both all zeros. Either bank can still be loaded.
- R10: The controls of one direction never change the bank content or the drive of the other direction, except through the clash rule of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data seen at the A pads |
| b_in | input | W | Data seen at the B pads |
| ab_en_n | input | 1 | A-to-B master enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A master enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_out | output | W | B-to-A bank content, toward the A pads |
| a_drv | output | W | Drive enable per A pad, all ones when driving |
| b_out | output | W | A-to-B bank content, toward the B pads |
| b_drv | output | W | Drive enable per B pad, all ones when driving |
| clash | output | 1 | Both directions asked to drive |

## Verification
The bench aims at the edge where a bank freezes, through the latch enable and separately through the master enable. A design that takes one extra or one fewer sample around that edge holds the wrong word. A design that ignores the master enable as a freeze source keeps following the source. Hold windows change the source on purpose, so a leaky latch shows up as a moving output. The output enable is toggled while the bank keeps loading, and this exposes drive tied to the wrong control. Both directions are enabled together, so a missing clash suppression drives both ports. A long mixed stretch, compared cycle by cycle against a model, catches crosstalk between the two banks.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        BANK_HOLD = 1'b0,
        BANK_PASS = 1'b1
    } bank_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_TO_B  = 2'd1,
        BUS_TO_A  = 2'd2,
        BUS_CLASH = 2'd3
    } bus_state_t;

endpackage

// File: rtl/xcvr_bank.sv
module xcvr_bank
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_n,
    input  logic         le_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] held
);

    bank_state_t state_q;
    bank_state_t state_d;
    logic [W-1:0] store_q;

    // next state: open when both low, capture when either is high
    always_comb begin
        unique case ({en_n, le_n})
            2'b00:   state_d = BANK_PASS;
            default: state_d = BANK_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BANK_HOLD;
        else     state_q <= state_d;
    end

    // storage follows the state decided at the previous edge
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            unique case (state_q)
                BANK_PASS: store_q <= src;
                BANK_HOLD: store_q <= store_q;
            endcase
        end
    end

    assign held = store_q;

endmodule

// File: rtl/xcvr_arbiter.sv
module xcvr_arbiter
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_b,
    input  logic req_a,
    output logic drive_b,
    output logic drive_a,
    output logic clash
);

    bus_state_t state_q;
    bus_state_t state_d;

    always_comb begin
        unique case ({req_a, req_b})
            2'b00: state_d = BUS_IDLE;
            2'b01: state_d = BUS_TO_B;
            2'b10: state_d = BUS_TO_A;
            2'b11: state_d = BUS_CLASH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= BUS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        drive_b = 1'b0;
        drive_a = 1'b0;
        clash   = 1'b0;
        unique case (state_q)
            BUS_IDLE:  ;
            BUS_TO_B:  drive_b = 1'b1;
            BUS_TO_A:  drive_a = 1'b1;
            BUS_CLASH: clash   = 1'b1;
        endcase
    end

endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    output logic         clash
);

    localparam int NDIR = 2;   // 0: A-to-B, 1: B-to-A

    logic [NDIR-1:0] en_n_v;
    logic [NDIR-1:0] le_n_v;
    logic [W-1:0]    src_v  [NDIR];
    logic [W-1:0]    bank_v [NDIR];

    assign en_n_v   = {ba_en_n, ab_en_n};
    assign le_n_v   = {ba_le_n, ab_le_n};
    assign src_v[0] = a_in;
    assign src_v[1] = b_in;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        xcvr_bank #(.W(W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .en_n (en_n_v[d]),
            .le_n (le_n_v[d]),
            .src  (src_v[d]),
            .held (bank_v[d])
        );
    end

    logic drive_b;
    logic drive_a;

    xcvr_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .req_b   (~ab_en_n & ~ab_oe_n),
        .req_a   (~ba_en_n & ~ba_oe_n),
        .drive_b (drive_b),
        .drive_a (drive_a),
        .clash   (clash)
    );

    assign b_out = bank_v[0];
    assign a_out = bank_v[1];
    assign b_drv = {W{drive_b}};
    assign a_drv = {W{drive_a}};

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_en_n,
    input logic         ab_le_n,
    input logic         ab_oe_n,
    input logic         ba_en_n,
    input logic         ba_le_n,
    input logic         ba_oe_n,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_drv,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_drv,
    input logic         clash
);

    // R9
    clash_silent_chk: assert property (@(posedge clk) disable iff (rst)
        clash |-> (a_drv == '0 && b_drv == '0));

    // R9
    clash_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ab_en_n && !ab_oe_n && !ba_en_n && !ba_oe_n)) |-> clash);

    // R6
    b_drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (b_drv != '0) |-> $past(!ab_en_n && !ab_oe_n));

    // R8
    a_drive_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (a_drv != '0) |-> $past(!ba_en_n && !ba_oe_n));

    // R5
    ab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ab_le_n | ab_en_n, 2)) |-> $stable(b_out));

    // R2
    ab_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(ab_le_n | ab_en_n, 2))
            |-> (b_out == $past(a_in)));

    // R8
    ba_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(ba_le_n | ba_en_n, 2))
            |-> (a_out == $past(b_in)));

endmodule

bind dual_latch_xcvr xcvr_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
    .clash(clash)
);

// File: tb/tb_dual_latch_xcvr.sv
module tb_dual_latch_xcvr;

    localparam int  W        = 8;
    localparam time CLK_T    = 10ns;
    localparam int  WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
    logic [W-1:0] a_out, a_drv, b_out, b_drv;
    logic clash;

    always #(CLK_T/2) clk = ~clk;

    dual_latch_xcvr #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv),
        .clash(clash)
    );

    typedef struct packed {
        logic [W-1:0] a_out;
        logic [W-1:0] a_drv;
        logic [W-1:0] b_out;
        logic [W-1:0] b_drv;
        logic         clash;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_vec  = 0;
    int    n_fail = 0;

    // reference state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic m_pass_ab = 1'b0, m_pass_ba = 1'b0;
    logic m_db = 1'b0, m_da = 1'b0, m_cl = 1'b0;

    // driver: one clock, update model from the requirements, queue result
    task automatic step(input string tag);
        logic wa, wb;
        exp_t e;
        @(posedge clk);
        if (rst) begin
            m_ab = '0; m_ba = '0; m_pass_ab = 1'b0; m_pass_ba = 1'b0;
            m_db = 1'b0; m_da = 1'b0; m_cl = 1'b0;
        end else begin
            if (m_pass_ab) m_ab = a_in;
            if (m_pass_ba) m_ba = b_in;
            m_pass_ab = !ab_en_n && !ab_le_n;
            m_pass_ba = !ba_en_n && !ba_le_n;
            wb = !ab_en_n && !ab_oe_n;
            wa = !ba_en_n && !ba_oe_n;
            m_cl = wa && wb;
            m_db = wb && !m_cl;
            m_da = wa && !m_cl;
        end
        e.a_out = m_ba; e.a_drv = {W{m_da}};
        e.b_out = m_ab; e.b_drv = {W{m_db}};
        e.clash = m_cl;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // monitor: compare at the falling edge after each queued edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  g;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            g = '{a_out, a_drv, b_out, b_drv, clash};
            n_vec++;
            if (g !== e) begin
                n_fail++;
                $display("FAIL %s: got a_out=%h a_drv=%h b_out=%h b_drv=%h clash=%b exp a_out=%h a_drv=%h b_out=%h b_drv=%h clash=%b",
                         t, g.a_out, g.a_drv, g.b_out, g.b_drv, g.clash,
                         e.a_out, e.a_drv, e.b_out, e.b_drv, e.clash);
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) step("R1");
        rst = 1'b0;
        step("R1");

        // R2 pass mode A-to-B, outputs on
        ab_en_n = 0; ab_le_n = 0; ab_oe_n = 0;
        for (int i = 0; i < 6; i++) begin
            a_in = 8'h11 * i[7:0] + 8'h05;
            step("R2");
        end

        // R3 freeze through latch enable, then R5 source moves
        a_in = 8'h3C; ab_le_n = 1; step("R3");
        a_in = 8'hC3; step("R3");
        for (int i = 0; i < 4; i++) begin
            a_in = 8'hA0 + i[7:0];
            step("R5");
        end

        // R6 output enable toggled while passing
        ab_le_n = 0; a_in = 8'h5A; step("R6");
        ab_oe_n = 1; a_in = 8'h66; step("R6");
        a_in = 8'h77; step("R6");
        ab_oe_n = 0; step("R6");

        // R4 freeze through master enable; R7 blocks drive and update
        a_in = 8'h96; ab_en_n = 1; step("R4");
        a_in = 8'h01; step("R7");
        ab_le_n = 0; ab_oe_n = 0; a_in = 8'hFE; step("R7");
        step("R7");

        // R8 mirror direction; R10 A-to-B bank untouched
        ab_en_n = 1;
        ba_en_n = 0; ba_le_n = 0; ba_oe_n = 0;
        for (int i = 0; i < 4; i++) begin
            b_in = 8'h21 + 8'h13 * i[7:0];
            step("R8");
        end
        b_in = 8'hE7; ba_le_n = 1; step("R8");
        b_in = 8'h18; step("R8");
        step("R10");

        // R9 both directions want the bus
        ba_le_n = 0; ab_en_n = 0; ab_le_n = 0; ab_oe_n = 0;
        a_in = 8'h42; b_in = 8'h24; step("R9");
        a_in = 8'h43; b_in = 8'h25; step("R9");
        step("R9");
        ba_oe_n = 1; step("R9");
        step("R9");

        // R10 mixed traffic against the model
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = $urandom;
            a_in = r[7:0]; b_in = r[15:8];
            ab_en_n = r[16] & r[22]; ab_le_n = r[17]; ab_oe_n = r[18];
            ba_en_n = r[19] & r[23]; ba_le_n = r[20]; ba_oe_n = r[21];
            rst = (r[31:26] == 6'd0);
            step("R10");
        end
        rst = 1'b0;

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule